// File: doc/BRIEF.md
# Multichannel audio sample FIFO

This block buffers interleaved multichannel audio samples between a processor and a serial audio shifter. The processor reaches it through four word locations on a small register bus: a data location, a control location and a status location (the fourth reads as zero). In playback the processor writes samples into the data location and the shifter draws them out one per strobe. In capture the shifter delivers samples one per strobe and the processor reads them from the data location. The direction, channel count and storage size code are configuration inputs.

The usable depth is derived from the configuration. A size code selects a raw storage of 256 words shifted left by the code. Frames are allocated in slots whose width is the channel count rounded up to a power of two, so odd channel counts leave part of the storage idle. The fill level is kept in samples and reported to software in whole frames. The block also has sticky overrun and underrun flags, and a half-level interrupt whose sense depends on the direction.

Top module: `audio_frame_fifo`

## Requirements
- R1: Sample capacity is ((256 << s) / p) * c. Here s is the size code clamped to MAX_SIZE_CODE, c is the channel count clamped to 1..8, and p is c rounded up to a power of two (1, 2, 4 or 8). Exactly that many pushes are accepted into an empty FIFO.
- R2: Status bits 16:8 report the stored sample count divided by the channel count, saturating at 511.
- R3: Samples leave in the order they entered, with all 24 data bits intact. A 16-bit sample placed in bits 23:8 with a zero low byte returns unchanged.
- R4: A push while the FIFO holds its full sample capacity is discarded and sets the overrun flag, status bit 4.
- R5: A pop from an empty FIFO returns zero, leaves the level at zero and sets the underrun flag, status bit 0.
- R6: Both flags are sticky. A write to the status location clears each flag whose bit is written 0 and keeps each flag whose bit is written 1. A new error in the same cycle wins.
- R7: Writing control with bit 0 set empties the FIFO. The error flags are unaffected.
- R8: irq equals control bit 20 ANDed with a level condition. In playback the condition is 2*level <= capacity. In capture it is 2*level >= capacity.
- R9: Direction, channel count and size code are taken only while the FIFO is empty or being emptied. Changes made while data is held have no effect on the frame count.
- R10: With cfg_capture low, data-location writes push and ser_take pops onto ser_out. With it high, ser_give pushes ser_in and data-location reads pop onto cpu_rdata.
- R11: After reset the status reads zero, control reads zero and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_sel | input | 1 | Register access this cycle |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 2 | 0 data, 1 control, 2 status |
| cpu_wdata | input | 24 | Write data |
| cpu_rdata | output | 24 | Read data, valid in the access cycle |
| cfg_capture | input | 1 | 1 = capture direction |
| cfg_chans | input | 4 | Channels per frame, 1 to 8 |
| cfg_size | input | 3 | Storage size code |
| ser_take | input | 1 | Shifter pops one sample (playback) |
| ser_out | output | 24 | Sample popped by ser_take |
| ser_give | input | 1 | Shifter pushes one sample (capture) |
| ser_in | input | 24 | Sample pushed by ser_give |
| irq | output | 1 | Half-level interrupt |

## Verification
The hardest state to reach from the ports is a FIFO holding exactly its derived capacity for every channel count and both size codes. That case includes the one-channel large-storage case, where the frame field must saturate. To reach each of the sixteen configurations, the bench clears the FIFO, changes the configuration and writes one sample per cycle until the computed capacity is reached. It then pushes once more to provoke the overrun. Holding the configuration while data is present is shown by changing the channel count mid-fill and observing that the frame count still divides by the old value.

// File: rtl/audio_frame_fifo.sv
module audio_frame_fifo #(
  parameter int DATA_W        = 24,
  parameter int MAX_SIZE_CODE = 1,
  parameter int FRAME_W       = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_sel,
  input  logic              cpu_wr,
  input  logic [1:0]        cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              cfg_capture,
  input  logic [3:0]        cfg_chans,
  input  logic [2:0]        cfg_size,
  input  logic              ser_take,
  output logic [DATA_W-1:0] ser_out,
  input  logic              ser_give,
  input  logic [DATA_W-1:0] ser_in,
  output logic              irq
);
  localparam int RAW_MAX   = 256 << MAX_SIZE_CODE;
  localparam int AW        = $clog2(RAW_MAX);
  localparam int LW        = AW + 1;
  localparam int FRAME_MAX = (1 << FRAME_W) - 1;

  function automatic logic [LW-1:0] calc_cap(input int s, input int c);
    int raw, lg;
    raw = 256 << s;
    lg  = (c <= 1) ? 0 : (c <= 2) ? 1 : (c <= 4) ? 2 : 3;
    return LW'((raw >> lg) * c);
  endfunction

  logic [DATA_W-1:0] mem [RAW_MAX];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [LW-1:0]     level_q, cap_q;
  logic [3:0]        chans_q;
  logic              capture_q, irq_en_q, ovr_q, und_q;

  wire data_wr = cpu_sel &  cpu_wr & (cpu_addr == 2'd0);
  wire data_rd = cpu_sel & ~cpu_wr & (cpu_addr == 2'd0);
  wire ctl_wr  = cpu_sel &  cpu_wr & (cpu_addr == 2'd1);
  wire st_wr   = cpu_sel &  cpu_wr & (cpu_addr == 2'd2);
  wire clr     = ctl_wr & cpu_wdata[0];

  wire [3:0] chans_in = (cfg_chans == 4'd0) ? 4'd1 : (cfg_chans > 4'd8) ? 4'd8 : cfg_chans;
  wire [2:0] size_in  = (int'(cfg_size) > MAX_SIZE_CODE) ? 3'(MAX_SIZE_CODE) : cfg_size;

  wire push_req = capture_q ? ser_give : data_wr;
  wire pop_req  = capture_q ? data_rd  : ser_take;
  wire [DATA_W-1:0] push_val = capture_q ? ser_in : cpu_wdata;

  wire full     = level_q >= cap_q;
  wire empty    = level_q == '0;
  wire push_ok  = push_req & ~full  & ~clr;
  wire pop_ok   = pop_req  & ~empty & ~clr;

  wire [DATA_W-1:0] pop_val = empty ? '0 : mem[rd_ptr];

  logic [LW-1:0]      frames_full;
  logic [FRAME_W-1:0] frames;
  assign frames_full = level_q / LW'(chans_q);
  assign frames      = (int'(frames_full) > FRAME_MAX) ? FRAME_W'(FRAME_MAX) : frames_full[FRAME_W-1:0];

  wire [DATA_W-1:0] status_word  = {7'b0, frames, 3'b0, ovr_q, 3'b0, und_q};
  wire [DATA_W-1:0] control_word = {3'b0, irq_en_q, 20'b0};

  always_comb begin
    case (cpu_addr)
      2'd0:    cpu_rdata = capture_q ? pop_val : '0;
      2'd1:    cpu_rdata = control_word;
      2'd2:    cpu_rdata = status_word;
      default: cpu_rdata = '0;
    endcase
  end

  assign ser_out = capture_q ? '0 : pop_val;

  wire [LW:0] twice = {level_q, 1'b0};
  assign irq = irq_en_q & (capture_q ? (twice >= {1'b0, cap_q}) : (twice <= {1'b0, cap_q}));

  always_ff @(posedge clk)
    if (push_ok) mem[wr_ptr] <= push_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      level_q   <= '0;
      cap_q     <= calc_cap(0, 1);
      chans_q   <= 4'd1;
      capture_q <= 1'b0;
      irq_en_q  <= 1'b0;
      ovr_q     <= 1'b0;
      und_q     <= 1'b0;
    end else begin
      if (clr) begin
        wr_ptr  <= '0;
        rd_ptr  <= '0;
        level_q <= '0;
      end else begin
        if (push_ok) wr_ptr <= wr_ptr + 1'b1;
        if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
        if (push_ok && !pop_ok)      level_q <= level_q + 1'b1;
        else if (pop_ok && !push_ok) level_q <= level_q - 1'b1;
      end
      if (empty || clr) begin
        cap_q     <= calc_cap(int'(size_in), int'(chans_in));
        chans_q   <= chans_in;
        capture_q <= cfg_capture;
      end
      if (ctl_wr) irq_en_q <= cpu_wdata[20];
      ovr_q <= (st_wr ? (ovr_q & cpu_wdata[4]) : ovr_q) | (push_req & full);
      und_q <= (st_wr ? (und_q & cpu_wdata[0]) : und_q) | (pop_req & empty);
    end
  end

  a_r1_level_within_cap: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= cap_q);
  a_r4_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && full) |=> ovr_q);
  a_r5_underrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && empty) |=> (und_q && level_q == '0));
  a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (level_q == '0));
  a_r9_config_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !clr) |=> ($stable(cap_q) && $stable(chans_q) && $stable(capture_q)));
  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (level_q == $past(level_q) || level_q == $past(level_q) + 1'b1
              || level_q == $past(level_q) - 1'b1));
endmodule

// File: tb/sim_audio_frame_fifo.sv
module sim_audio_frame_fifo;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cpu_sel = 0, cpu_wr = 0;
  logic [1:0]  cpu_addr = 0;
  logic [23:0] cpu_wdata = 0, cpu_rdata;
  logic        cfg_capture = 0;
  logic [3:0]  cfg_chans = 4'd1;
  logic [2:0]  cfg_size = 3'd0;
  logic        ser_take = 0, ser_give = 0;
  logic [23:0] ser_out, ser_in = 0;
  logic        irq;
  int checks = 0, errors = 0;

  audio_frame_fifo u0 (.clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cfg_capture(cfg_capture), .cfg_chans(cfg_chans), .cfg_size(cfg_size),
    .ser_take(ser_take), .ser_out(ser_out), .ser_give(ser_give), .ser_in(ser_in), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cpu(input logic wr, input logic [1:0] a, input logic [23:0] d, output logic [23:0] q);
    @(negedge clk);
    cpu_sel = 1; cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
    #1 q = cpu_rdata;
    @(posedge clk);
    #1 cpu_sel = 0; cpu_wr = 0;
  endtask

  task automatic take(output logic [23:0] q);
    @(negedge clk); ser_take = 1;
    #1 q = ser_out;
    @(posedge clk); #1 ser_take = 0;
  endtask

  task automatic give(input logic [23:0] d);
    @(negedge clk); ser_give = 1; ser_in = d;
    @(posedge clk); #1 ser_give = 0;
  endtask

  function automatic int cap_of(int s, int c);
    int p = 1;
    while (p < c) p = p * 2;
    return ((256 << s) / p) * c;
  endfunction

  task automatic restart(input logic cap_mode, input int c, input int s);
    logic [23:0] q;
    cfg_capture = cap_mode; cfg_chans = 4'(c); cfg_size = 3'(s);
    cpu(1, 2'd1, 24'h100001, q);
    cpu(1, 2'd2, 24'h0, q);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] q;
    int cap, fr;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cpu(0, 2'd2, 0, q); check("R11 status", q, 0);
    cpu(0, 2'd1, 0, q); check("R11 control", q, 0);
    check("R11 irq", irq, 0);

    for (int s = 0; s < 2; s++)
      for (int c = 1; c <= 8; c++) begin
        restart(0, c, s);
        cap = cap_of(s, c);
        for (int k = 0; k < cap; k++) cpu(1, 2'd0, 24'(k), q);
        cpu(0, 2'd2, 0, q);
        fr = (cap / c > 511) ? 511 : cap / c;
        check($sformatf("R1 R2 frames s%0d c%0d", s, c), q, 24'(fr << 8));
        check("R8 playback irq when full", irq, 0);
        cpu(1, 2'd0, 24'h5A5A5A, q);
        cpu(0, 2'd2, 0, q);
        check($sformatf("R4 overrun s%0d c%0d", s, c), q, 24'((fr << 8) | 32'h10));
      end

    cpu(1, 2'd1, 24'h000001, q);
    cpu(0, 2'd2, 0, q); check("R7 clear keeps flags", q, 24'h10);
    take(q); check("R5 empty pop data", q, 0);
    cpu(0, 2'd2, 0, q); check("R5 underrun flag", q, 24'h11);
    cpu(1, 2'd2, 24'h10, q);
    cpu(0, 2'd2, 0, q); check("R6 selective clear", q, 24'h10);
    cpu(1, 2'd2, 24'h0, q);
    cpu(0, 2'd2, 0, q); check("R6 write zero", q, 0);

    restart(0, 2, 0);
    cpu(1, 2'd0, 24'h123400, q);
    cpu(1, 2'd0, 24'hABCDEF, q);
    cpu(1, 2'd0, 24'h000001, q);
    take(q); check("R3 16-bit aligned", q, 24'h123400);
    take(q); check("R3 order 2", q, 24'hABCDEF);
    take(q); check("R3 order 3", q, 24'h000001);

    restart(0, 3, 0);
    check("R8 irq at empty", irq, 1);
    for (int k = 0; k < 96; k++) cpu(1, 2'd0, 24'(k), q);
    check("R8 irq at half", irq, 1);
    cpu(1, 2'd0, 24'h1, q);
    check("R8 irq above half", irq, 0);
    cpu(1, 2'd1, 24'h000000, q);
    check("R8 irq disabled", irq, 0);

    restart(0, 2, 0);
    for (int k = 0; k < 4; k++) cpu(1, 2'd0, 24'(k), q);
    cfg_chans = 4'd4;
    repeat (2) @(posedge clk);
    cpu(0, 2'd2, 0, q); check("R9 chans held", q, 24'h000200);

    restart(1, 1, 0);
    give(24'h111111); give(24'h222222);
    cpu(0, 2'd0, 0, q); check("R10 capture read 1", q, 24'h111111);
    cpu(0, 2'd0, 0, q); check("R10 capture read 2", q, 24'h222222);
    check("R8 capture irq low", irq, 0);
    cpu(0, 2'd0, 0, q); check("R5 capture empty read", q, 0);
    cpu(0, 2'd2, 0, q); check("R5 capture underrun", q, 24'h1);
    for (int k = 0; k < 257; k++) give(24'(k));
    cpu(0, 2'd2, 0, q); check("R4 capture overrun", q, 24'h010011);
    check("R8 capture irq high", irq, 1);
    cpu(0, 2'd0, 0, q); check("R10 capture head", q, 24'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule